// File: doc/BRIEF.md
# Bus-Master DMA Channel Registers

This block holds the programming registers and the control sequencing for one bus-master DMA channel that works next to a SCSI protocol core. Software reaches eight 32-bit word registers through a simple register port. A command write selects one of four operations. The start operation copies the programmed start values into the working registers and raises an enable line toward the SCSI core.

While a transfer runs, the memory-side mover offers bursts. For each burst the block grants the smaller of the requested length and the remaining working count. It then moves the working count down and the working address up by the granted amount. A burst in the wrong direction is refused. When the SCSI core reports command completion, the remaining count is forced to zero and a done flag is set.

The status flags can be cleared in two ways. A write can clear them bit by bit, or a status read can clear them. A mode input selects which policy applies. A live interrupt flag from the SCSI core is merged into every status read.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, command reads 0, working count reads 0, working address reads 0xFFFFFFFF, working descriptor address reads 0xFFFFFFFD, status reads 0, and both `dma_en` and `abort_req` are low.
- R2: Word offsets are command 0, start count 1, start address 2, working count 3, working address 4, status 5, start descriptor 6 and working descriptor 7. Command and the three start registers read back what was written. Writes to offsets 3, 4 and 7 leave those registers unchanged.
- R3: Writing command with bits [1:0] = 3 (start) has three effects. It loads working count, working address and working descriptor from their start registers. It clears status bits 5..0. It raises `dma_en` on the next cycle.
- R4: Command bits [1:0] = 0 (idle) drop `dma_en` on the next cycle. Bits [1:0] = 1 (blast) leave `dma_en` and the counters unchanged.
- R5: Command bits [1:0] = 2 (abort) raise `abort_req` for exactly one cycle after the write, and `dma_en` is left unchanged.
- R6: A burst whose direction matches command bit 7 is granted `xfer_take` = min(`xfer_len`, working count). Here bit 7 = 1 and `xfer_to_mem` = 1 both mean device to memory. On the next cycle the working count is lower by `xfer_take` and the working address is higher by `xfer_take`.
- R7: A burst in the other direction is granted 0, and it leaves working count and working address unchanged.
- R8: A `scsi_done` pulse forces the working count to 0 and sets status bit 3 (done).
- R9: With `clr_on_rd` = 0, a status write clears only those of bits 1, 2 and 3 that are 1 in the written data. Status reads have no side effect in this mode.
- R10: With `clr_on_rd` = 1, status writes are ignored. A status read returns the current flags and then clears bits 1, 2 and 3.
- R11: While `scsi_irq` is high, a status read returns bit 4 set, whatever the stored value of that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; it matters only for the status clear-on-read |
| addr | input | 3 | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| clr_on_rd | input | 1 | Status clear policy: 1 selects clear-on-read, 0 selects write-one-to-clear |
| scsi_irq | input | 1 | Live interrupt flag from the SCSI core |
| xfer_valid | input | 1 | Burst request from the memory mover |
| xfer_to_mem | input | 1 | Burst direction; 1 means device to memory |
| xfer_len | input | LEN_W | Requested burst length in bytes |
| xfer_take | output | 32 | Granted burst length, 0 when the burst is refused |
| xfer_addr | output | 32 | Current working address for the burst |
| scsi_done | input | 1 | SCSI command completion pulse |
| dma_en | output | 1 | DMA enable to the SCSI core |
| abort_req | output | 1 | One-cycle request to cancel the active SCSI request |

## Verification
The bench builds the block with the default LEN_W of 17. At that width a single request can ask for 0x10000 bytes or more, so a burst can be longer than the remaining count and the grant limit is reached. The bench also uses bursts shorter than the count and a burst against a zero count. Both policy settings are exercised, and the interrupt merge is checked in each.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             clr_on_rd,
  input  logic             scsi_irq,
  input  logic             xfer_valid,
  input  logic             xfer_to_mem,
  input  logic [LEN_W-1:0] xfer_len,
  output logic [31:0]      xfer_take,
  output logic [31:0]      xfer_addr,
  input  logic             scsi_done,
  output logic             dma_en,
  output logic             abort_req
);
  localparam logic [5:0] CLR_MASK = 6'b001110;

  logic [31:0] cmd_q, scnt_q, sadr_q, wcnt_q, wadr_q, sdsc_q, wdsc_q;
  logic [5:0]  stat_q;
  logic        en_q, abort_q;

  wire        wr_cmd  = wr_en && addr == 3'd0;
  wire [1:0]  op      = wdata[1:0];
  wire        dir_ok  = cmd_q[7] == xfer_to_mem;
  wire [31:0] len_ext = 32'(xfer_len);
  wire [31:0] grant   = (len_ext < wcnt_q) ? len_ext : wcnt_q;
  wire [5:0]  stat_rd = stat_q | {1'b0, scsi_irq, 4'b0};

  assign xfer_take = (xfer_valid && dir_ok) ? grant : 32'd0;
  assign xfer_addr = wadr_q;
  assign dma_en    = en_q;
  assign abort_req = abort_q;

  always_comb begin
    case (addr)
      3'd0: rdata = cmd_q;
      3'd1: rdata = scnt_q;
      3'd2: rdata = sadr_q;
      3'd3: rdata = wcnt_q;
      3'd4: rdata = wadr_q;
      3'd5: rdata = {26'd0, stat_rd};
      3'd6: rdata = sdsc_q;
      default: rdata = wdsc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      scnt_q  <= '0;
      sadr_q  <= '0;
      wcnt_q  <= '0;
      wadr_q  <= 32'hFFFF_FFFF;
      sdsc_q  <= '0;
      wdsc_q  <= 32'hFFFF_FFFD;
      stat_q  <= '0;
      en_q    <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (rd_en && addr == 3'd5 && clr_on_rd)
        stat_q <= stat_q & ~CLR_MASK;
      if (wr_en) begin
        case (addr)
          3'd0: begin
            cmd_q <= wdata;
            case (op)
              2'd0: en_q <= 1'b0;
              2'd2: abort_q <= 1'b1;
              2'd3: begin
                wcnt_q <= scnt_q;
                wadr_q <= sadr_q;
                wdsc_q <= sdsc_q;
                stat_q <= '0;
                en_q   <= 1'b1;
              end
              default: ;
            endcase
          end
          3'd1: scnt_q <= wdata;
          3'd2: sadr_q <= wdata;
          3'd5: if (!clr_on_rd) stat_q <= stat_q & ~(wdata[5:0] & CLR_MASK);
          3'd6: sdsc_q <= wdata;
          default: ;
        endcase
      end
      if (|xfer_take) begin
        wcnt_q <= wcnt_q - xfer_take;
        wadr_q <= wadr_q + xfer_take;
      end
      if (scsi_done) begin
        wcnt_q    <= '0;
        stat_q[3] <= 1'b1;
      end
    end
  end

  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  // R3
  start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && op == 2'd3 |=> dma_en);

  // R4
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && op == 2'd0 |=> !dma_en);

  // R5
  abort_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> $past(wr_cmd && op == 2'd2));

  // R7
  wrong_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !dir_ok && !wr_en && !scsi_done |=> $stable(wcnt_q) && $stable(wadr_q));

  // R8
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scsi_done |=> wcnt_q == 32'd0 && stat_q[3]);
endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata, xfer_take, xfer_addr;
  logic clr_on_rd = 0, scsi_irq = 0, xfer_valid = 0, xfer_to_mem = 0, scsi_done = 0;
  logic [16:0] xfer_len = 0;
  logic dma_en, abort_req;
  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  dma_chan_regs #(.LEN_W(17)) u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #2;
    if (rd_en && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1; addr = a; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic burst(input logic dir, input logic [16:0] len, input logic [31:0] e, input string tag);
    @(negedge clk); xfer_valid = 1; xfer_to_mem = dir; xfer_len = len;
    #2 chk(tag, xfer_take, e);
    @(negedge clk); xfer_valid = 0;
  endtask

  task automatic done_pulse;
    @(negedge clk); scsi_done = 1;
    @(negedge clk); scsi_done = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2 chk("R1 dma_en", {31'd0, dma_en}, 0);
    chk("R1 abort_req", {31'd0, abort_req}, 0);
    rd(0, 0, "R1 cmd");
    rd(3, 0, "R1 wcnt");
    rd(4, 32'hFFFFFFFF, "R1 wadr");
    rd(7, 32'hFFFFFFFD, "R1 wdsc");
    rd(5, 0, "R1 status");

    wr(1, 32'h40); wr(2, 32'h1000); wr(6, 32'h2000);
    rd(1, 32'h40, "R2 scnt"); rd(2, 32'h1000, "R2 sadr"); rd(6, 32'h2000, "R2 sdsc");
    wr(3, 32'h55); rd(3, 0, "R2 wcnt write ignored");
    wr(4, 32'h77); rd(4, 32'hFFFFFFFF, "R2 wadr write ignored");
    wr(7, 32'h99); rd(7, 32'hFFFFFFFD, "R2 wdsc write ignored");

    wr(0, 32'h83);
    #2 chk("R3 dma_en", {31'd0, dma_en}, 1);
    rd(0, 32'h83, "R2 cmd");
    rd(3, 32'h40, "R3 wcnt"); rd(4, 32'h1000, "R3 wadr"); rd(7, 32'h2000, "R3 wdsc");

    burst(1, 17'h10, 32'h10, "R6 short take");
    rd(3, 32'h30, "R6 wcnt"); rd(4, 32'h1010, "R6 wadr");
    #2 chk("R6 xfer_addr", xfer_addr, 32'h1010);
    burst(0, 17'h8, 0, "R7 wrong dir take");
    rd(3, 32'h30, "R7 wcnt"); rd(4, 32'h1010, "R7 wadr");
    burst(1, 17'h10000, 32'h30, "R6 capped take");
    rd(3, 0, "R6 wcnt zero"); rd(4, 32'h1040, "R6 wadr end");
    burst(1, 17'h4, 0, "R6 empty count take");

    wr(0, 32'h81);
    #2 chk("R4 blast keeps en", {31'd0, dma_en}, 1);
    rd(3, 0, "R4 blast counters");
    @(negedge clk); wr_en = 1; addr = 0; wdata = 32'h82;
    @(negedge clk); wr_en = 0;
    #2 chk("R5 abort pulse", {31'd0, abort_req}, 1);
    chk("R5 en kept", {31'd0, dma_en}, 1);
    @(negedge clk);
    #2 chk("R5 abort one cycle", {31'd0, abort_req}, 0);
    wr(0, 32'h80);
    #2 chk("R4 idle drops en", {31'd0, dma_en}, 0);

    scsi_irq = 1;
    rd(5, 32'h10, "R11 irq merged");
    scsi_irq = 0;
    rd(5, 0, "R11 irq gone");

    wr(0, 32'h03);
    rd(3, 32'h40, "R3 reload wcnt");
    done_pulse();
    rd(3, 0, "R8 wcnt forced");
    rd(5, 32'h08, "R8 done set");
    rd(5, 32'h08, "R9 read no side effect");
    wr(5, 32'h06); rd(5, 32'h08, "R9 unselected kept");
    wr(5, 32'h08); rd(5, 0, "R9 w1c cleared");

    done_pulse();
    wr(0, 32'h03); rd(5, 0, "R3 start clears status");

    clr_on_rd = 1;
    done_pulse();
    wr(5, 32'h08);
    rd(5, 32'h08, "R10 write ignored");
    rd(5, 0, "R10 cleared by read");
    scsi_irq = 1;
    rd(5, 32'h10, "R11 irq in cor mode");
    scsi_irq = 0;

    repeat (3) @(negedge clk);
    chk("queue drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule